// File: doc/BRIEF.md
# OTG Control-Line Edge Interrupt Wrapper

This block sits beside a USB OTG controller and turns activity on four OTG control lines into interrupts. Software drives the lines (VBUS drive, VBUS charge, VBUS discharge and ID pull-up) by writing a control register. The block compares each line with its value one clock earlier. A rising or a falling transition each sets its own status bit. Two more status bits catch an OTG-event pulse and a DMA-disable-cleared pulse. These ten bits form interrupt group 1. Group 0 holds a single bit, which latches a core-interrupt request.

Each group has a raw status view, a masked status view and an enable mask. The enable mask is changed only through separate write-1-to-set and write-1-to-clear registers. Software clears status by writing back the value it read from the masked status register. An end-of-interrupt write pulls the chosen interrupt line low for one cycle. Edge-triggered receivers then see a new edge when work is still pending.

Top module: `otgEdgeIrq`

## Requirements
- R1: After reset all status bits, both enable masks, the control register and the stored previous line values are zero, both interrupt lines are low, and every register reads 0.
- R2: The control register at offset 0x80 holds the lines drive (bit 5), charge (bit 4), discharge (bit 3) and pull-up (bit 0). Other bits are not stored and read as 0.
- R3: A 0-to-1 change of a control bit sets the group 1 rise bit of that line: drive at 13, charge at 12, discharge at 11, pull-up at 8. The bit shows in raw status after the clock that follows the register update.
- R4: A 1-to-0 change of a control bit sets the group 1 fall bit of that line, at the same position as the control bit (5, 4, 3, 0), with the same timing as R3.
- R5: An OTG-event input high at a clock edge sets group 1 bit 16. A DMA-disable-cleared input high sets group 1 bit 17. A core-interrupt input high sets group 0 bit 0.
- R6: Writing 1s to enable-set (group 0 at 0x2C, group 1 at 0x3C) sets those enable bits. Writing 1s to enable-clear (0x30, 0x40) clears them. Both offsets of a group read back the current mask. Only defined status bits can be enabled.
- R7: Raw status reads at 0x24 (group 0) and 0x34 (group 1). Masked status, equal to raw AND enable, reads at 0x28 and 0x38.
- R8: Writing to masked status clears the raw bits written as 1 and leaves the bits written as 0. Writes to the raw status offsets have no effect.
- R9: When an event sets a status bit in the same cycle that software clears it, the bit stays set.
- R10: Interrupt line 0 (line 1) is high while group 0 (group 1) masked status is nonzero, except as stated in R11.
- R11: A write to offset 0x20 acknowledges line 0 when data bit 0 is 0 and line 1 when it is 1. The acknowledged line is low for the one cycle after the write, then follows R10 again. The other line is unaffected.
- R12: Offset 0x20 and unmapped offsets read 0, and writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe, one write per asserted cycle |
| regAddr | input | ADDR_W | Register byte offset |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr (combinational) |
| coreIrqIn | input | 1 | Core interrupt request |
| otgEvtIn | input | 1 | OTG event pulse |
| dmaDisClrIn | input | 1 | DMA-disable-cleared pulse |
| irqLine0 | output | 1 | Group 0 interrupt line |
| irqLine1 | output | 1 | Group 1 interrupt line |

## Verification
An event setting a status bit can land in the same clock as a software write that clears that bit. This is provoked in two ways. One is a control-register write whose edge event arrives on the next cycle, timed to meet a status write that clears the resulting rise bit. The other is an OTG-event pulse driven in the same cycle as a clear of bit 16. In both cases the bit must survive in raw status and in the interrupt line. A long stretch of random register traffic and input pulses then gives many more such collisions. These include clashes between end-of-interrupt writes and new events. A behavioural model, compared on every clock, judges all of them.

// File: rtl/otgEdgeIrqPkg.sv
package otgEdgeIrqPkg;
  localparam int DATA_W = 32;

  // byte offsets of the register map
  localparam logic [31:0] OFF_EOI  = 32'h20;
  localparam logic [31:0] OFF_RAW0 = 32'h24;
  localparam logic [31:0] OFF_STS0 = 32'h28;
  localparam logic [31:0] OFF_SET0 = 32'h2C;
  localparam logic [31:0] OFF_CLR0 = 32'h30;
  localparam logic [31:0] OFF_RAW1 = 32'h34;
  localparam logic [31:0] OFF_STS1 = 32'h38;
  localparam logic [31:0] OFF_SET1 = 32'h3C;
  localparam logic [31:0] OFF_CLR1 = 32'h40;
  localparam logic [31:0] OFF_CTL  = 32'h80;

  // control lines live at bits 5,4,3,0; rise bits sit RISE_SHIFT higher
  localparam logic [DATA_W-1:0] CTL_MASK   = 32'h0000_0039;
  localparam int                RISE_SHIFT = 8;
  localparam int                OTG_BIT    = 16;
  localparam int                DMA_BIT    = 17;
  localparam logic [DATA_W-1:0] G0_MASK    = 32'h0000_0001;
  localparam logic [DATA_W-1:0] G1_MASK    = (CTL_MASK << RISE_SHIFT) | CTL_MASK
                                           | (32'h1 << OTG_BIT) | (32'h1 << DMA_BIT);

  typedef enum logic [2:0] {
    RD_NONE, RD_RAW0, RD_STS0, RD_EN0, RD_RAW1, RD_STS1, RD_EN1, RD_CTL
  } rdSel_e;

  typedef struct packed {
    logic eoi;
    logic sts0;
    logic set0;
    logic clr0;
    logic sts1;
    logic set1;
    logic clr1;
    logic ctl;
  } wrStb_t;
endpackage

// File: rtl/otgEdgeIrqDecode.sv
module otgEdgeIrqDecode
  import otgEdgeIrqPkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  output wrStb_t            wrStb,
  output rdSel_e            rdSel
);
  logic [31:0] addrExt;
  assign addrExt = 32'(regAddr);

  always_comb begin
    wrStb = '0;
    rdSel = RD_NONE;
    case (addrExt)
      OFF_EOI:  wrStb.eoi  = regWe;
      OFF_RAW0: rdSel = RD_RAW0;
      OFF_STS0: begin rdSel = RD_STS0; wrStb.sts0 = regWe; end
      OFF_SET0: begin rdSel = RD_EN0;  wrStb.set0 = regWe; end
      OFF_CLR0: begin rdSel = RD_EN0;  wrStb.clr0 = regWe; end
      OFF_RAW1: rdSel = RD_RAW1;
      OFF_STS1: begin rdSel = RD_STS1; wrStb.sts1 = regWe; end
      OFF_SET1: begin rdSel = RD_EN1;  wrStb.set1 = regWe; end
      OFF_CLR1: begin rdSel = RD_EN1;  wrStb.clr1 = regWe; end
      OFF_CTL:  begin rdSel = RD_CTL;  wrStb.ctl  = regWe; end
      default:  ;
    endcase
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wrStb)) else $error("decode raised several strobes"); // R12
  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !regWe |-> (wrStb == '0)) else $error("strobe without write"); // R12
endmodule

// File: rtl/otgEdgeIrqRegs.sv
module otgEdgeIrqRegs
  import otgEdgeIrqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  wrStb_t            wrStb,
  input  rdSel_e            rdSel,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              coreIrqIn,
  input  logic              otgEvtIn,
  input  logic              dmaDisClrIn,
  output logic              irqLine0,
  output logic              irqLine1
);
  logic [DATA_W-1:0] raw0, raw1, en0, en1, ctl, prevCtl;
  logic [DATA_W-1:0] riseVec, fallVec, set0, set1, clr0, clr1;
  logic              hold0, hold1;

  // edge detection against the value held one clock earlier
  assign riseVec = ctl & ~prevCtl & CTL_MASK;
  assign fallVec = ~ctl & prevCtl & CTL_MASK;
  assign set1    = (riseVec << RISE_SHIFT) | fallVec
                 | (DATA_W'(otgEvtIn) << OTG_BIT) | (DATA_W'(dmaDisClrIn) << DMA_BIT);
  assign set0    = DATA_W'(coreIrqIn);
  assign clr1    = wrStb.sts1 ? (regWdata & G1_MASK) : '0;
  assign clr0    = wrStb.sts0 ? (regWdata & G0_MASK) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      raw0    <= '0;
      raw1    <= '0;
      en0     <= '0;
      en1     <= '0;
      ctl     <= '0;
      prevCtl <= '0;
      hold0   <= 1'b0;
      hold1   <= 1'b0;
    end else begin
      // a new event outranks a clear in the same cycle
      raw0    <= (raw0 & ~clr0) | set0;
      raw1    <= (raw1 & ~clr1) | set1;
      if (wrStb.set0) en0 <= en0 | (regWdata & G0_MASK);
      if (wrStb.clr0) en0 <= en0 & ~regWdata;
      if (wrStb.set1) en1 <= en1 | (regWdata & G1_MASK);
      if (wrStb.clr1) en1 <= en1 & ~regWdata;
      prevCtl <= ctl;
      if (wrStb.ctl) ctl <= regWdata & CTL_MASK;
      hold0   <= wrStb.eoi & ~regWdata[0];
      hold1   <= wrStb.eoi & regWdata[0];
    end
  end

  assign irqLine0 = (|(raw0 & en0)) & ~hold0;
  assign irqLine1 = (|(raw1 & en1)) & ~hold1;

  always_comb begin
    case (rdSel)
      RD_RAW0: regRdata = raw0;
      RD_STS0: regRdata = raw0 & en0;
      RD_EN0:  regRdata = en0;
      RD_RAW1: regRdata = raw1;
      RD_STS1: regRdata = raw1 & en1;
      RD_EN1:  regRdata = en1;
      RD_CTL:  regRdata = ctl;
      default: regRdata = '0;
    endcase
  end

  AST_EDGE_SETS_RISE: assert property (@(posedge clk) disable iff (!rstN)
    ((ctl & ~prevCtl & CTL_MASK) != '0) |=> (raw1[13:8] != '0)) else $error("rise lost"); // R3
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (set1 != '0) |=> ((raw1 & $past(set1)) == $past(set1))) else $error("event dropped"); // R9
  AST_ENABLE_SET: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb.set1 && !wrStb.clr1) |=> ((en1 & $past(regWdata & G1_MASK)) == $past(regWdata & G1_MASK)))
    else $error("enable set failed"); // R6
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    wrStb.sts1 |=> ((raw1 & $past(regWdata & G1_MASK & ~set1)) == '0)) else $error("clear failed"); // R8
  AST_EOI_DROP0: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb.eoi && !regWdata[0]) |=> !irqLine0) else $error("line 0 not dropped"); // R11
  AST_EOI_DROP1: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb.eoi && regWdata[0]) |=> !irqLine1) else $error("line 1 not dropped"); // R11
endmodule

// File: rtl/otgEdgeIrq.sv
module otgEdgeIrq
  import otgEdgeIrqPkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              coreIrqIn,
  input  logic              otgEvtIn,
  input  logic              dmaDisClrIn,
  output logic              irqLine0,
  output logic              irqLine1
);
  wrStb_t wrStb;
  rdSel_e rdSel;

  otgEdgeIrqDecode #(.ADDR_W(ADDR_W)) u_decode (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .wrStb(wrStb), .rdSel(rdSel)
  );

  otgEdgeIrqRegs u_regs (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .rdSel(rdSel),
    .regWdata(regWdata), .regRdata(regRdata),
    .coreIrqIn(coreIrqIn), .otgEvtIn(otgEvtIn), .dmaDisClrIn(dmaDisClrIn),
    .irqLine0(irqLine0), .irqLine1(irqLine1)
  );
endmodule

// File: tb/otgEdgeIrq_tb.sv
module otgEdgeIrq_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        coreIrqIn = 1'b0, otgEvtIn = 1'b0, dmaDisClrIn = 1'b0;
  logic        irqLine0, irqLine1;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  string tag = "R1";

  // behavioural reference state
  logic [31:0] mRaw0 = 0, mRaw1 = 0, mEn0 = 0, mEn1 = 0, mCtl = 0, mPrev = 0;
  bit mHold0 = 0, mHold1 = 0;

  always #5 clk = ~clk;

  otgEdgeIrq #(.ADDR_W(12)) u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .coreIrqIn(coreIrqIn), .otgEvtIn(otgEvtIn),
    .dmaDisClrIn(dmaDisClrIn), .irqLine0(irqLine0), .irqLine1(irqLine1)
  );

  function automatic logic [31:0] expRead(input logic [11:0] a);
    case (a)
      12'h24: return mRaw0;
      12'h28: return mRaw0 & mEn0;
      12'h2C, 12'h30: return mEn0;
      12'h34: return mRaw1;
      12'h38: return mRaw1 & mEn1;
      12'h3C, 12'h40: return mEn1;
      12'h80: return mCtl;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s addr=%h actual=%h expected=%h", tag, what, regAddr, act, exp);
    end
  endtask

  task automatic modelStep();
    logic [31:0] rise, fall, s1, c1, c0;
    rise = mCtl & ~mPrev & 32'h39;
    fall = ~mCtl & mPrev & 32'h39;
    s1 = (rise << 8) | fall | (32'(otgEvtIn) << 16) | (32'(dmaDisClrIn) << 17);
    c1 = (regWe && regAddr == 12'h38) ? (regWdata & 32'h0003_3939) : 32'h0;
    c0 = (regWe && regAddr == 12'h28) ? (regWdata & 32'h1) : 32'h0;
    mRaw1 = (mRaw1 & ~c1) | s1;
    mRaw0 = (mRaw0 & ~c0) | 32'(coreIrqIn);
    if (regWe && regAddr == 12'h2C) mEn0 = mEn0 | (regWdata & 32'h1);
    if (regWe && regAddr == 12'h30) mEn0 = mEn0 & ~regWdata;
    if (regWe && regAddr == 12'h3C) mEn1 = mEn1 | (regWdata & 32'h0003_3939);
    if (regWe && regAddr == 12'h40) mEn1 = mEn1 & ~regWdata;
    mPrev = mCtl;
    if (regWe && regAddr == 12'h80) mCtl = regWdata & 32'h39;
    mHold0 = regWe && regAddr == 12'h20 && !regWdata[0];
    mHold1 = regWe && regAddr == 12'h20 && regWdata[0];
  endtask

  // one clock: drive at the falling edge, compare, then advance the model
  task automatic tick(input bit we, input logic [11:0] a, input logic [31:0] d,
                      input bit core = 0, input bit otg = 0, input bit dma = 0);
    regWe = we; regAddr = a; regWdata = d;
    coreIrqIn = core; otgEvtIn = otg; dmaDisClrIn = dma;
    #1;
    check("rdata", regRdata, expRead(a));
    check("irq0", 32'(irqLine0), 32'((|(mRaw0 & mEn0)) && !mHold0));
    check("irq1", 32'(irqLine1), 32'((|(mRaw1 & mEn1)) && !mHold1));
    @(posedge clk);
    modelStep();
    @(negedge clk);
  endtask

  task automatic rd(input logic [11:0] a);
    tick(0, a, 32'h0);
  endtask

  initial begin : watchdog
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : stim
    logic [11:0] addrs [12];
    addrs = '{12'h20, 12'h24, 12'h28, 12'h2C, 12'h30, 12'h34,
              12'h38, 12'h3C, 12'h40, 12'h80, 12'h50, 12'h84};
    repeat (3) @(negedge clk);
    // R1: reset values
    tag = "R1";
    check("irq0 in reset", 32'(irqLine0), 32'h0);
    rstN = 1'b1;
    foreach (addrs[i]) rd(addrs[i]);

    // R2 and R3: drive all lines high, unused bits dropped
    tag = "R2"; tick(1, 12'h80, 32'hFFFF_FFFF); rd(12'h80);
    tag = "R3"; rd(12'h34); rd(12'h34);
    // R6: enable set / clear, both offsets read mask
    tag = "R6"; tick(1, 12'h3C, 32'hFFFF_FFFF); rd(12'h3C); rd(12'h40);
    tick(1, 12'h40, 32'h0000_0800); rd(12'h3C);
    // R7 and R10: masked view and line 1
    tag = "R7"; rd(12'h38); tag = "R10"; rd(12'h24);
    // R8: raw write ignored, status write clears only 1 bits
    tag = "R8"; tick(1, 12'h34, 32'hFFFF_FFFF); rd(12'h34);
    tick(1, 12'h38, 32'h0000_0100); rd(12'h34);
    tick(1, 12'h38, 32'h0); rd(12'h34);
    // R4: all lines low
    tag = "R4"; tick(1, 12'h80, 32'h0); rd(12'h80); rd(12'h34);
    // R5: pulses and core request
    tag = "R5"; tick(0, 12'h24, 0, 1, 1, 1); rd(12'h24); rd(12'h34);
    tick(1, 12'h2C, 32'h1); rd(12'h28);
    // R11: acknowledge each line, other line untouched
    tag = "R11"; tick(1, 12'h20, 32'h0); rd(12'h28); rd(12'h28);
    tick(1, 12'h20, 32'h1); rd(12'h38); rd(12'h38);
    // R9: clear of bit 8 meets its rise event; clear of bit 16 meets OTG pulse
    tag = "R9"; tick(1, 12'h38, 32'h0003_3939); rd(12'h34);
    tick(1, 12'h80, 32'h1);
    tick(1, 12'h38, 32'h0000_0100); rd(12'h34);
    tick(1, 12'h38, 32'h0001_0000, 0, 1, 0); rd(12'h34);
    // R12: unmapped write and reads
    tag = "R12"; tick(1, 12'h50, 32'hFFFF_FFFF); rd(12'h50); rd(12'h20); rd(12'h80);

    // random traffic with collisions of every kind
    tag = "R9";
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom;
      tick(r[0] && r[1], addrs[r[5:2] % 12], $urandom, r[8] && r[9], r[10] && r[11], r[12] && r[13]);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule